// File: doc/BRIEF.md
# Three-Wire Serial Register Port

This block is the slave side of a three-wire control port that reaches a bank of 8-bit configuration registers. A host lowers an active-low select line, clocks a 16-bit frame on a serial clock, and drives the frame bits on a shared data line. The first seven bits carry the register address. The eighth bit is the direction, and the last eight bits are data. The register bank has 23 entries, at addresses 00h to 16h, and it is held inside the block.

Read data can leave the block in two ways. With the routing bit clear, the shared data line turns around during the data phase and each bit is launched from a falling edge of the serial clock. With the routing bit set, the data goes out on a separate output pin and each bit is launched from a rising edge. The serial inputs are sampled by the block's own clock through synchronizers, and the edges of the serial clock are found from those samples. Each pin that can float has its own output enable, so a low enable means high impedance.

Top module: `regAccessPort`

## Requirements
- R1: A frame is 16 bits, most significant bit first: address bits 6..0, then a direction bit (1 = write, 0 = read), then data bits 7..0. A write frame stores its data byte in the addressed register, and a later read of that address returns it.
- R2: Bits are captured only on rising edges of `sclk` while `csN` is low. Edges beyond the sixteenth in one select window are ignored.
- R3: When bit 0 of register 14h is 0, read data goes out on `sioOut`. `sioOe` rises after the falling edge that follows the eighth rising edge, and each of D7..D0 is launched from a falling edge. `soOe` stays low.
- R4: When bit 0 of register 14h is 1, read data goes out on `soOut`. D7 is launched from the eighth rising edge and D6..D0 from the following rising edges. `sioOe` stays low.
- R5: `sioOe` and `soOe` are never high together. Both are low during write frames, during the address phase of a read, and once `csN` is high again.
- R6: A frame cut short by raising `csN` before its sixteenth rising edge changes no register.
- R7: Writes to addresses above 16h change no register. Reads from those addresses return 00h.
- R8: Raising `csN` clears the bit count and the output enables, so the next frame starts from its first address bit.
- R9: An active-low `rstN` asynchronously clears every register to 00h, disables both outputs and selects the shared-line read mode.
- R10: A read frame leaves the addressed register unchanged, whatever bits the host drives during the data phase.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock used to sample the serial pins |
| rstN | input | 1 | Asynchronous reset, active low |
| sclk | input | 1 | Serial clock from the host |
| csN | input | 1 | Frame select, active low |
| sioIn | input | 1 | Input side of the shared data line |
| sioOut | output | 1 | Read data driven onto the shared line |
| sioOe | output | 1 | Drive enable for the shared line (0 = high impedance) |
| soOut | output | 1 | Read data on the dedicated output pin |
| soOe | output | 1 | Drive enable for the dedicated pin (0 = high impedance) |

## Verification
The bench goes after frames cut short at 12 and 15 bits. A design that committed data early would corrupt the register there. It clocks frames past 16 bits, where a counter that wraps would start a second, phantom access. It writes to the edge address 16h and just above it, and to the top of the address space, to catch an off-by-one bound or an address that aliases into the bank. The routing bit is switched many times between random frames. A design that launched read data on the wrong clock edge would return the byte shifted by one bit, and one that drove the wrong pin would show up as an enable seen at the wrong moment.

// File: rtl/regAccessPkg.sv
package regAccessPkg;

  localparam int ADDR_W     = 7;
  localparam int DATA_W     = 8;
  localparam int FRAME_BITS = ADDR_W + 1 + DATA_W;
  localparam int CNT_W      = $clog2(FRAME_BITS + 1);

  // per-cycle events handed from the control side to the datapath
  typedef struct packed {
    logic             capture;     // rising sclk edge that carries a frame bit
    logic             launchFall;  // falling sclk edge while selected
    logic             inBit;       // synchronized data line value
    logic             idle;        // select released
    logic [CNT_W-1:0] bitIdx;      // bits already received in this frame
  } strobeT;

endpackage

// File: rtl/regAccessCtrl.sv
module regAccessCtrl
  import regAccessPkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic   clk,
  input  logic   rstN,
  input  logic   sclk,
  input  logic   csN,
  input  logic   sioIn,
  output strobeT strb
);

  localparam logic [CNT_W-1:0] FRAME_CNT = CNT_W'(FRAME_BITS);
  localparam int               TOP       = SYNC_STAGES - 1;

  logic [SYNC_STAGES-1:0] sclkSync;
  logic [SYNC_STAGES-1:0] csSync;
  logic [SYNC_STAGES-1:0] sioSync;
  logic                   sclkPrev;
  logic [CNT_W-1:0]       bitCnt;

  logic selected;
  logic riseEdge;
  logic fallEdge;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sclkSync <= '0;
      csSync   <= '1;
      sioSync  <= '0;
      sclkPrev <= 1'b0;
    end else begin
      sclkSync <= {sclkSync[TOP-1:0], sclk};
      csSync   <= {csSync[TOP-1:0], csN};
      sioSync  <= {sioSync[TOP-1:0], sioIn};
      sclkPrev <= sclkSync[TOP];
    end
  end

  assign selected = ~csSync[TOP];
  assign riseEdge = selected &  sclkSync[TOP] & ~sclkPrev;
  assign fallEdge = selected & ~sclkSync[TOP] &  sclkPrev;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      bitCnt <= '0;
    end else if (!selected) begin
      bitCnt <= '0;
    end else if (riseEdge && (bitCnt < FRAME_CNT)) begin
      bitCnt <= bitCnt + CNT_W'(1);
    end
  end

  always_comb begin
    strb.capture    = riseEdge && (bitCnt < FRAME_CNT);
    strb.launchFall = fallEdge;
    strb.inBit      = sioSync[TOP];
    strb.idle       = ~selected;
    strb.bitIdx     = bitCnt;
  end

endmodule

// File: rtl/regAccessDatapath.sv
module regAccessDatapath
  import regAccessPkg::*;
#(
  parameter int                NUM_REGS  = 23,
  parameter logic [ADDR_W-1:0] MODE_ADDR = 7'h14
) (
  input  logic   clk,
  input  logic   rstN,
  input  strobeT strb,
  output logic   sioOut,
  output logic   sioOe,
  output logic   soOut,
  output logic   soOe
);

  localparam int               SH_W     = (ADDR_W > DATA_W - 1) ? ADDR_W : DATA_W - 1;
  localparam logic [CNT_W-1:0] DIR_IDX  = CNT_W'(ADDR_W);
  localparam logic [CNT_W-1:0] LAST_IDX = CNT_W'(FRAME_BITS - 1);

  logic [DATA_W-1:0]   regFile [NUM_REGS];
  logic [NUM_REGS-1:0] wrHit;

  logic [SH_W-1:0]   inSh;
  logic [ADDR_W-1:0] addrReg;
  logic              dirWr;
  logic              rdSio;
  logic              rdSo;
  logic [DATA_W-1:0] outSh;

  logic [ADDR_W-1:0] addrNow;
  logic [DATA_W-1:0] rdMux;
  logic [DATA_W-1:0] wrData;
  logic              modeBit;
  logic              dirStrobe;
  logic              wrStrobe;

  assign addrNow   = inSh[ADDR_W-1:0];
  assign wrData    = {inSh[DATA_W-2:0], strb.inBit};
  assign dirStrobe = strb.capture && (strb.bitIdx == DIR_IDX);
  assign wrStrobe  = strb.capture && (strb.bitIdx == LAST_IDX) && dirWr;

  // read selection and routing bit, decoded without a wide array index
  always_comb begin
    rdMux   = '0;
    modeBit = 1'b0;
    for (int i = 0; i < NUM_REGS; i++) begin
      if (addrNow == ADDR_W'(i)) rdMux = regFile[i];
      if (MODE_ADDR == ADDR_W'(i)) modeBit = regFile[i][0];
    end
  end

  for (genvar i = 0; i < NUM_REGS; i++) begin : g_reg
    assign wrHit[i] = wrStrobe && (addrReg == ADDR_W'(i));

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        regFile[i] <= '0;
      end else if (wrHit[i]) begin
        regFile[i] <= wrData;
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      inSh    <= '0;
      addrReg <= '0;
      dirWr   <= 1'b0;
      rdSio   <= 1'b0;
      rdSo    <= 1'b0;
      outSh   <= '0;
      sioOut  <= 1'b0;
      sioOe   <= 1'b0;
      soOut   <= 1'b0;
      soOe    <= 1'b0;
    end else if (strb.idle) begin
      inSh    <= '0;
      addrReg <= '0;
      dirWr   <= 1'b0;
      rdSio   <= 1'b0;
      rdSo    <= 1'b0;
      outSh   <= '0;
      sioOut  <= 1'b0;
      sioOe   <= 1'b0;
      soOut   <= 1'b0;
      soOe    <= 1'b0;
    end else begin
      if (strb.capture) begin
        inSh <= {inSh[SH_W-2:0], strb.inBit};
      end

      if (dirStrobe) begin
        addrReg <= addrNow;
        dirWr   <= strb.inBit;
        if (!strb.inBit) begin
          if (modeBit) begin
            rdSo  <= 1'b1;
            soOe  <= 1'b1;
            soOut <= rdMux[DATA_W-1];
            outSh <= {rdMux[DATA_W-2:0], 1'b0};
          end else begin
            rdSio <= 1'b1;
            outSh <= rdMux;
          end
        end
      end

      // dedicated pin: following bits on rising edges
      if (strb.capture && rdSo && (strb.bitIdx > DIR_IDX) && (strb.bitIdx < LAST_IDX)) begin
        soOut <= outSh[DATA_W-1];
        outSh <= {outSh[DATA_W-2:0], 1'b0};
      end

      // shared line: every data bit on a falling edge
      if (strb.launchFall && rdSio && (strb.bitIdx > DIR_IDX) && (strb.bitIdx <= LAST_IDX)) begin
        sioOe  <= 1'b1;
        sioOut <= outSh[DATA_W-1];
        outSh  <= {outSh[DATA_W-2:0], 1'b0};
      end
    end
  end

endmodule

// File: rtl/regAccessPort.sv
module regAccessPort
  import regAccessPkg::*;
#(
  parameter int                NUM_REGS    = 23,
  parameter logic [ADDR_W-1:0] MODE_ADDR   = 7'h14,
  parameter int                SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rstN,
  input  logic sclk,
  input  logic csN,
  input  logic sioIn,
  output logic sioOut,
  output logic sioOe,
  output logic soOut,
  output logic soOe
);

  strobeT strb;

  regAccessCtrl #(
    .SYNC_STAGES(SYNC_STAGES)
  ) u_ctrl (
    .clk  (clk),
    .rstN (rstN),
    .sclk (sclk),
    .csN  (csN),
    .sioIn(sioIn),
    .strb (strb)
  );

  regAccessDatapath #(
    .NUM_REGS (NUM_REGS),
    .MODE_ADDR(MODE_ADDR)
  ) u_dp (
    .clk   (clk),
    .rstN  (rstN),
    .strb  (strb),
    .sioOut(sioOut),
    .sioOe (sioOe),
    .soOut (soOut),
    .soOe  (soOe)
  );

endmodule

// File: rtl/regAccessPortChk.sv
module regAccessPortChk
  import regAccessPkg::*;
(
  input logic             clk,
  input logic             rstN,
  input logic             idle,
  input logic             capture,
  input logic             launchFall,
  input logic [CNT_W-1:0] bitIdx,
  input logic             sioOut,
  input logic             sioOe,
  input logic             soOut,
  input logic             soOe
);

  assert_single_driver_R5: assert property (@(posedge clk) disable iff (!rstN)
    !(sioOe && soOe));

  assert_release_clears_R8: assert property (@(posedge clk) disable iff (!rstN)
    idle |=> (!sioOe && !soOe && (bitIdx == '0)));

  assert_count_bound_R2: assert property (@(posedge clk) disable iff (!rstN)
    bitIdx <= CNT_W'(FRAME_BITS));

  assert_sio_on_fall_R3: assert property (@(posedge clk) disable iff (!rstN)
    (sioOe && $past(sioOe) && !$stable(sioOut)) |-> $past(launchFall));

  assert_sio_enable_on_fall_R3: assert property (@(posedge clk) disable iff (!rstN)
    $rose(sioOe) |-> $past(launchFall));

  assert_so_on_rise_R4: assert property (@(posedge clk) disable iff (!rstN)
    (soOe && $past(soOe) && !$stable(soOut)) |-> $past(capture));

  assert_so_enable_on_rise_R4: assert property (@(posedge clk) disable iff (!rstN)
    $rose(soOe) |-> $past(capture));

endmodule

bind regAccessPort regAccessPortChk u_chk (
  .clk       (clk),
  .rstN      (rstN),
  .idle      (strb.idle),
  .capture   (strb.capture),
  .launchFall(strb.launchFall),
  .bitIdx    (strb.bitIdx),
  .sioOut    (sioOut),
  .sioOe     (sioOe),
  .soOut     (soOut),
  .soOe      (soOe)
);

// File: tb/regAccessPort_bench.sv
module regAccessPort_bench;

  localparam int NUM_REGS = 23;
  localparam int MODE_REG = 'h14;
  localparam int HALF     = 8;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic rstN, sclk, csN, sioIn;
  logic sioOut, sioOe, soOut, soOe;

  int checks = 0;
  int fails  = 0;
  logic [7:0] model [NUM_REGS];

  regAccessPort u_regAccessPort (
    .clk   (clk),
    .rstN  (rstN),
    .sclk  (sclk),
    .csN   (csN),
    .sioIn (sioIn),
    .sioOut(sioOut),
    .sioOe (sioOe),
    .soOut (soOut),
    .soOe  (soOe)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic waitClk(input int n);
    repeat (n) @(negedge clk);
  endtask

  function automatic logic [7:0] expectRead(input logic [6:0] a);
    if (int'(a) < NUM_REGS) return model[int'(a)];
    return 8'h00;
  endfunction

  // one select window; read data is picked from the pin that the model's routing bit names
  task automatic runFrame(input logic [6:0] a, input logic d, input logic [7:0] wd,
                          input int nbits, output logic [7:0] rd, output logic badOe);
    logic [15:0] f;
    logic soMode;
    f      = {a, d, wd};
    soMode = model[MODE_REG][0];
    rd     = 8'h00;
    badOe  = 1'b0;
    csN    = 1'b0;
    waitClk(HALF);
    for (int i = 0; i < nbits; i++) begin
      sioIn = (i < 16) ? f[15-i] : 1'b1;
      waitClk(HALF);
      if ((sioOe && (d || soMode || i < 8)) || (soOe && (d || !soMode || i < 8))) badOe = 1'b1;
      if (!d && !soMode && i >= 8 && i <= 15) begin
        rd[15-i] = sioOut;
        if (!sioOe) badOe = 1'b1;
      end
      sclk = 1'b1;
      waitClk(HALF);
      if (!d && soMode && i >= 7 && i <= 14) begin
        rd[14-i] = soOut;
        if (!soOe) badOe = 1'b1;
      end
      sclk = 1'b0;
    end
    waitClk(HALF);
    csN = 1'b1;
    waitClk(HALF);
    if (d && nbits >= 16 && int'(a) < NUM_REGS) model[int'(a)] = wd;
  endtask

  task automatic writeReg(input logic [6:0] a, input logic [7:0] v, input string req);
    logic [7:0] rd;
    logic badOe;
    runFrame(a, 1'b1, v, 16, rd, badOe);
    chk({req, " R5 no drive on write"}, {31'd0, badOe}, 32'd0);
  endtask

  task automatic readReg(input logic [6:0] a, input string req);
    logic [7:0] rd;
    logic [7:0] exp;
    logic badOe;
    exp = expectRead(a);
    runFrame(a, 1'b0, 8'hFF, 16, rd, badOe);
    chk(req, {24'd0, rd}, {24'd0, exp});
    chk({req, " R5 enable timing"}, {31'd0, badOe}, 32'd0);
    chk({req, " R5 released"}, {30'd0, sioOe, soOe}, 32'd0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL R8 watchdog actual=running expected=finished");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    logic [7:0] rd;
    logic badOe;
    void'($urandom(32'd20231));
    for (int i = 0; i < NUM_REGS; i++) model[i] = 8'h00;
    rstN = 1'b0; csN = 1'b1; sclk = 1'b0; sioIn = 1'b0;
    waitClk(5);
    chk("R9 enables low in reset", {30'd0, sioOe, soOe}, 32'd0);
    rstN = 1'b1;
    waitClk(5);

    readReg(7'h00, "R9 reset value reg 00h");
    readReg(7'h16, "R9 reset value reg 16h");

    writeReg(7'h05, 8'hA5, "R1");
    readReg(7'h05, "R1 write then read 05h");
    writeReg(7'h16, 8'h3C, "R1");
    readReg(7'h16, "R1 top address 16h");

    runFrame(7'h05, 1'b0, 8'h00, 16, rd, badOe);
    readReg(7'h05, "R10 read frame keeps register");

    runFrame(7'h05, 1'b1, 8'h11, 12, rd, badOe);
    readReg(7'h05, "R6 frame cut at 12 bits");
    runFrame(7'h05, 1'b1, 8'h22, 15, rd, badOe);
    readReg(7'h05, "R6 frame cut at 15 bits");
    runFrame(7'h05, 1'b0, 8'h00, 10, rd, badOe);
    readReg(7'h16, "R8 fresh frame after cut read");

    runFrame(7'h03, 1'b1, 8'h5A, 19, rd, badOe);
    readReg(7'h03, "R2 extra edges ignored");

    writeReg(7'h17, 8'hFF, "R7");
    writeReg(7'h7F, 8'hEE, "R7");
    readReg(7'h17, "R7 read 17h");
    readReg(7'h7F, "R7 read 7Fh");
    readReg(7'h16, "R7 16h untouched");

    writeReg(7'h14, 8'h01, "R4");
    readReg(7'h05, "R4 dedicated pin read 05h");
    readReg(7'h14, "R4 dedicated pin read 14h");
    writeReg(7'h14, 8'h00, "R3");
    readReg(7'h05, "R3 shared line read 05h");

    for (int n = 0; n < 60; n++) begin
      logic [6:0] a;
      logic [7:0] v;
      a = (($urandom % 8) == 0) ? 7'($urandom % 128) : 7'($urandom % 24);
      v = 8'($urandom);
      if (($urandom % 5) == 0) a = 7'h14;
      if ($urandom % 2) begin
        writeReg(a, v, "R1 random");
      end else if (model[MODE_REG][0]) begin
        readReg(a, "R4 random read");
      end else begin
        readReg(a, "R3 random read");
      end
    end

    writeReg(7'h14, 8'h01, "R9");
    rstN = 1'b0;
    waitClk(3);
    chk("R9 enables low after reset", {30'd0, sioOe, soOe}, 32'd0);
    rstN = 1'b1;
    for (int i = 0; i < NUM_REGS; i++) model[i] = 8'h00;
    waitClk(3);
    readReg(7'h14, "R9 routing bit cleared");
    readReg(7'h16, "R9 register cleared");

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule